// File: doc/BRIEF.md
# Two-Input Fuzzy Performance-Index Engine

This block scores a candidate (for example one car in a group of lifts) from two unsigned 8-bit measurements: a distance figure and a count of pending stops. Each measurement is graded against five triangular fuzzy sets, from very small up to very large. Only the pair of neighbouring sets that a value actually touches carries weight, so the block keeps just that pair of degrees and a 2-bit segment code for each input. The two segment codes pick a 2x2 window out of a 5x5 rule grid, so every evaluation fires exactly four rules. The rule grid's output depends only on the sum of the row and column indices, so one small adder on the two segment codes gives the window's contents.

Each rule's strength is the minimum of its two input degrees. Each output set keeps the strongest rule that points at it. The crisp index is the centre-weighted average of the output sets. A multi-cycle restoring divider computes that average. A caller offers an operand pair with a valid/ready handshake. The engine accepts it only while idle and later holds the 8-bit index with a valid flag until the caller takes it.

Top module: `fz_engine`

## Requirements
- R1: While reset is held and on the cycle after it is released, `inReady` is 1, `outValid` is 0 and `outPi` is 0. Reset is synchronous to `clk`.
- R2: An input x is fuzzified with segment s = x[7:6] and offset f = x[5:0]. The upper degree is B = 4*f + floor(f/16) and the lower degree is A = 255 - B. The degree of set s (sets numbered 0..4) is A, the degree of set s+1 is B, and every other set has degree 0.
- R3: The rule for distance set i and stops set j drives output set 4 - floor((i+j+1)/2). Only the four rules with i in {sA, sA+1} and j in {sB, sB+1} are evaluated, and rules outside that window have zero strength under R2.
- R4: A rule's firing strength is the minimum of its two input degrees. An output set's strength is the maximum over the rules that drive it.
- R5: The output sets have singleton centres 0, 64, 128, 192 and 255. `outPi` is floor(sum(strength*centre) / sum(strength)), and 0 if every strength is zero.
- R6: An operand pair is taken only on a clock edge where `inValid` and `inReady` are both 1. While the engine is busy, `inReady` is 0, and `inValid` and the operand inputs have no effect on the result.
- R7: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outPi` does not change.
- R8: On an edge with `outValid` and `outReady` both 1, the engine returns to idle: on the next cycle `inReady` is 1 and `outValid` is 0.
- R9: Asserting reset in the middle of a computation abandons it and returns the engine to the state of R1.
- R10: `outValid` becomes 1 exactly 9 clock edges after the accepting edge: one edge for the inference stage and one edge for each of the 8 quotient bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operand pair offered |
| inReady | output | 1 | Engine idle and able to accept |
| inDist | input | 8 | Crisp distance measurement |
| inStops | input | 8 | Crisp pending-stop measurement |
| outValid | output | 1 | Index available |
| outReady | input | 1 | Caller takes the index |
| outPi | output | 8 | Crisp performance index |

## Verification
The bench builds the engine with the package defaults: 8-bit inputs, five sets per input and an 8-step divider. With these values, every value of one input can be swept against sixteen evenly spaced values of the other, in both orientations. That sweep reaches every segment pair, both ends of every segment and every way the four window rules can merge onto shared output sets. The expected index comes from an all-25-rule reference inside the bench. The bench also measures the 9-edge latency on every run, holds results back to test the stall behaviour, injects requests while busy, and resets in the middle of a computation.

// File: rtl/fz_pkg.sv
package fz_pkg;

  localparam int unsigned X_W     = 8;              // crisp input width
  localparam int unsigned SEG_W   = 2;              // segment code width
  localparam int unsigned OFS_W   = X_W - SEG_W;    // offset inside a segment
  localparam int unsigned DEG_W   = X_W;            // membership degree width
  localparam int unsigned N_SETS  = (1 << SEG_W) + 1;
  localparam int unsigned SET_W   = $clog2(N_SETS);
  localparam int unsigned SUM_W   = SEG_W + 2;      // holds sA + sB + 2
  localparam int unsigned N_RULE  = 4;              // 2x2 window
  localparam int unsigned DEN_W   = DEG_W + $clog2(N_RULE) + 1;
  localparam int unsigned NUM_W   = DEN_W + X_W;
  localparam int unsigned Q_W     = X_W;            // quotient bits = divider steps
  localparam int unsigned CNT_W   = $clog2(Q_W);
  localparam int unsigned DEG_MAX = (1 << DEG_W) - 1;

  typedef struct packed {
    logic [SEG_W-1:0] seg;
    logic [DEG_W-1:0] lo;
    logic [DEG_W-1:0] hi;
  } fuzz_t;

  typedef struct packed {
    logic capture;   // latch a new operand pair
    logic load;      // latch numerator/denominator into the divider
    logic step;      // one restoring-division iteration
    logic commit;    // final iteration: publish the quotient
  } ctrl_t;

  // Neighbouring-pair fuzzification; lo + hi is always DEG_MAX.
  function automatic fuzz_t fuzzify(input logic [X_W-1:0] x);
    fuzz_t r;
    logic [OFS_W-1:0] f;
    f     = x[OFS_W-1:0];
    r.seg = x[X_W-1 -: SEG_W];
    r.hi  = {f, f[OFS_W-1 -: SEG_W]};
    r.lo  = ~r.hi;
    return r;
  endfunction

  // Rule consequent depends only on the summed set indices.
  function automatic logic [SET_W-1:0] outSet(input logic [SUM_W-1:0] s);
    int t;
    t = int'(N_SETS) - 1 - ((int'(s) + 1) / 2);
    return SET_W'(t);
  endfunction

  function automatic logic [X_W-1:0] centre(input int k);
    if (k == int'(N_SETS) - 1) return X_W'(DEG_MAX);
    return X_W'(k << OFS_W);
  endfunction

endpackage

// File: rtl/fz_control.sv
module fz_control
  import fz_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  inValid,
  input  logic  outReady,
  output logic  inReady,
  output logic  outValid,
  output ctrl_t ctrl
);

  typedef enum logic [1:0] {S_IDLE, S_CALC, S_DIV, S_DONE} state_t;

  state_t     state, stateNext;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    inReady   = 1'b0;
    outValid  = 1'b0;
    unique case (state)
      S_IDLE: begin
        inReady      = 1'b1;
        ctrl.capture = inValid;
        if (inValid) stateNext = S_CALC;
      end
      S_CALC: begin
        ctrl.load = 1'b1;
        stateNext = S_DIV;
      end
      S_DIV: begin
        ctrl.step = 1'b1;
        if (stepCnt == '0) begin
          ctrl.commit = 1'b1;
          stateNext   = S_DONE;
        end
      end
      S_DONE: begin
        outValid = 1'b1;
        if (outReady) stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      stepCnt <= '0;
    end else begin
      state <= stateNext;
      if (ctrl.load)      stepCnt <= CNT_W'(Q_W - 1);
      else if (ctrl.step) stepCnt <= stepCnt - 1'b1;
    end
  end

endmodule

// File: rtl/fz_datapath.sv
module fz_datapath
  import fz_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  ctrl_t          ctrl,
  input  logic [X_W-1:0] inDist,
  input  logic [X_W-1:0] inStops,
  output logic [X_W-1:0] resPi
);

  logic [X_W-1:0]   xDist, xStops;
  fuzz_t            fzDist, fzStops;
  logic [SUM_W-1:0] winSum;
  logic [DEG_W-1:0] ruleStr [N_RULE];
  logic [SET_W-1:0] ruleSet [N_RULE];
  logic [DEG_W-1:0] setStr  [N_SETS];
  logic [NUM_W-1:0] sumNum;
  logic [DEN_W-1:0] sumDen;

  // divider state
  logic [NUM_W-1:0] rem, dsh;
  logic [Q_W-1:0]   quo;
  logic             denZero;
  logic [NUM_W:0]   trial;
  logic             fits;

  always_comb begin
    fzDist  = fuzzify(xDist);
    fzStops = fuzzify(xStops);
    winSum  = SUM_W'(fzDist.seg) + SUM_W'(fzStops.seg);
  end

  // Window corner c: bit 1 picks the upper distance set, bit 0 the upper stops set.
  for (genvar c = 0; c < N_RULE; c++) begin : g_rule
    logic [DEG_W-1:0] dDeg, sDeg;
    assign dDeg       = c[1] ? fzDist.hi  : fzDist.lo;
    assign sDeg       = c[0] ? fzStops.hi : fzStops.lo;
    assign ruleStr[c] = (dDeg < sDeg) ? dDeg : sDeg;
    assign ruleSet[c] = outSet(winSum + SUM_W'(c[1]) + SUM_W'(c[0]));
  end

  always_comb begin
    for (int k = 0; k < N_SETS; k++) begin
      setStr[k] = '0;
      for (int c = 0; c < N_RULE; c++)
        if (ruleSet[c] == SET_W'(k) && ruleStr[c] > setStr[k])
          setStr[k] = ruleStr[c];
    end
    sumNum = '0;
    sumDen = '0;
    for (int k = 0; k < N_SETS; k++) begin
      sumNum = sumNum + NUM_W'(setStr[k]) * NUM_W'(centre(k));
      sumDen = sumDen + DEN_W'(setStr[k]);
    end
  end

  always_comb begin
    trial = {1'b0, rem} - {1'b0, dsh};
    fits  = ~trial[NUM_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xDist   <= '0;
      xStops  <= '0;
      rem     <= '0;
      dsh     <= '0;
      quo     <= '0;
      denZero <= 1'b0;
      resPi   <= '0;
    end else begin
      if (ctrl.capture) begin
        xDist  <= inDist;
        xStops <= inStops;
      end
      if (ctrl.load) begin
        rem     <= sumNum;
        dsh     <= NUM_W'(sumDen) << (Q_W - 1);
        quo     <= '0;
        denZero <= (sumDen == '0);
      end
      if (ctrl.step) begin
        if (fits) rem <= trial[NUM_W-1:0];
        dsh <= dsh >> 1;
        quo <= {quo[Q_W-2:0], fits};
      end
      if (ctrl.commit)
        resPi <= denZero ? '0 : X_W'({quo[Q_W-2:0], fits});
    end
  end

endmodule

// File: rtl/fz_engine.sv
module fz_engine
  import fz_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           inValid,
  output logic           inReady,
  input  logic [X_W-1:0] inDist,
  input  logic [X_W-1:0] inStops,
  output logic           outValid,
  input  logic           outReady,
  output logic [X_W-1:0] outPi
);

  ctrl_t ctrl;

  fz_control i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .ctrl     (ctrl)
  );

  fz_datapath i_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .inDist  (inDist),
    .inStops (inStops),
    .resPi   (outPi)
  );

endmodule

// File: rtl/fz_engine_chk.sv
module fz_engine_chk
  import fz_pkg::*;
#(
  parameter int unsigned LATENCY = Q_W + 1
) (
  input logic           clk,
  input logic           rst,
  input logic           inValid,
  input logic           inReady,
  input logic           outValid,
  input logic           outReady,
  input logic [X_W-1:0] outPi
);

  logic [4:0] latCnt;

  always_ff @(posedge clk) begin
    if (rst)                      latCnt <= '0;
    else if (inValid && inReady)  latCnt <= '0;
    else if (!inReady && !outValid && latCnt != '1) latCnt <= latCnt + 1'b1;
  end

  // R6: acceptance moves the engine out of idle
  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady |=> !inReady);

  // R6: never ready for input while a result is pending
  p_ready_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(inReady && outValid));

  // R7: a stalled result stays put
  p_hold_result_r7: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outPi));

  // R8: a taken result frees the engine
  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    outValid && outReady |=> inReady && !outValid);

  // R10: fixed latency from acceptance to result
  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> latCnt == 5'(LATENCY));

endmodule

bind fz_engine fz_engine_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outPi    (outPi)
);

// File: tb/test_fz_engine.sv
`timescale 1ns/1ps
module test_fz_engine;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] inDist = '0;
  logic [7:0] inStops = '0;
  logic       outValid;
  logic       outReady = 1'b0;
  logic [7:0] outPi;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  fz_engine i_fz_engine (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inDist(inDist), .inStops(inStops), .outValid(outValid),
    .outReady(outReady), .outPi(outPi)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Full 25-rule reference built from the requirements.
  function automatic int refPi(input int x1, input int x2);
    int mu1[5], mu2[5], agg[5];
    int s, f, b, st, o, num, den;
    for (int k = 0; k < 5; k++) begin mu1[k] = 0; mu2[k] = 0; agg[k] = 0; end
    s = x1 / 64; f = x1 % 64; b = 4*f + f/16; mu1[s] = 255 - b; mu1[s+1] = b;
    s = x2 / 64; f = x2 % 64; b = 4*f + f/16; mu2[s] = 255 - b; mu2[s+1] = b;
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++) begin
        st = (mu1[i] < mu2[j]) ? mu1[i] : mu2[j];
        o  = 4 - (i + j + 1) / 2;
        if (st > agg[o]) agg[o] = st;
      end
    num = 0; den = 0;
    for (int k = 0; k < 5; k++) begin
      num += agg[k] * ((k == 4) ? 255 : 64*k);
      den += agg[k];
    end
    return (den == 0) ? 0 : num / den;
  endfunction

  task automatic offer(input int x1, input int x2);
    @(negedge clk);
    inDist = 8'(x1); inStops = 8'(x2); inValid = 1'b1;
    @(posedge clk);
    #1 inValid = 1'b0;
  endtask

  task automatic awaitResult(output int edges);
    edges = 0;
    while (!outValid && edges < 40) begin
      @(posedge clk); #1; edges++;
    end
  endtask

  task automatic release_();
    @(negedge clk) outReady = 1'b1;
    @(posedge clk);
    #1 outReady = 1'b0;
    check(inReady === 1'b1 && outValid === 1'b0, "R8 idle after take",
          int'({inReady, outValid}), 2);
  endtask

  task automatic runOne(input int x1, input int x2, input int stall);
    int edges, exp;
    exp = refPi(x1, x2);
    offer(x1, x2);
    awaitResult(edges);
    check(edges == 9, "R10 latency", edges, 9);
    // value checks cover R2 R3 R4 R5
    check(outPi == 8'(exp), $sformatf("R5 index (R2 R3 R4) d=%0d s=%0d", x1, x2),
          int'(outPi), exp);
    if (stall > 0) begin
      repeat (stall) @(negedge clk);
      check(outValid === 1'b1 && outPi == 8'(exp), "R7 held while stalled",
            int'(outPi), exp);
    end
    release_();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int edges, exp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(inReady === 1'b1 && outValid === 1'b0 && outPi == 0, "R1 in reset",
          int'({inReady, outValid, outPi}), 512);
    rst = 1'b0;
    @(negedge clk);
    check(inReady === 1'b1 && outValid === 1'b0 && outPi == 0, "R1 after reset",
          int'({inReady, outValid, outPi}), 512);

    // Sweep: every distance against 16 stop values, then the reverse.
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 17)
        runOne(a, b, ((a + b) % 37 == 0) ? 3 : 0);
    for (int b = 0; b < 256; b++)
      for (int a = 0; a < 256; a += 17)
        runOne(a, b, 0);

    // R6: requests while busy are ignored
    exp = refPi(200, 30);
    offer(200, 30);
    @(negedge clk);
    inDist = 8'd5; inStops = 8'd250; inValid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(inReady === 1'b0, "R6 not ready while busy", int'(inReady), 0);
    end
    inValid = 1'b0;
    awaitResult(edges);
    check(outPi == 8'(exp), "R6 busy request ignored", int'(outPi), exp);
    release_();
    @(negedge clk);
    check(outValid === 1'b0, "R6 no extra result", int'(outValid), 0);

    // R9: reset mid computation
    runOne(100, 100, 0);
    offer(250, 10);
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(inReady === 1'b1 && outValid === 1'b0 && outPi == 0, "R9 abandoned",
          int'({inReady, outValid, outPi}), 512);
    repeat (12) @(negedge clk);
    check(outValid === 1'b0, "R9 no late result", int'(outValid), 0);
    runOne(250, 10, 2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule